// File: doc/BRIEF.md
# Link power-event interrupt register

This block collects four power-related events from the PHY-side logic of a serial bus link and presents them to a host as one status register, one enable register and a single active-high interrupt line. The events are: the PHY-link interface has finished initializing, the PHY has passed up a request to wake the link, the PHY clock is running, and the PHY clock has stopped. The event inputs are assumed to be already synchronized to the block clock.

Each status bit keeps to its own rule. The initialization-done and clock-running bits are sticky and cleared by writing 1. The wake-request bit is also cleared by writing 1, but it cannot clear while the request is still asserted. The clock-stopped bit carries no memory and always shows the live input. Writing 1 to a sticky bit and then reading it back gives the present state of the condition behind it, so the host can use the bit to sample that condition. For a wake-up, the host waits until the clock-running bit reads 1. It then clears the wake enable, and after that it writes 1 to the wake status bit to cancel the interrupt.

Top module: `pwr_event_irq`

## Requirements
- R1: Status bit 3 is set in the cycle after `initDone` is high. It stays set until the host writes a 1 to bit 3 of the status register.
- R2: Status bit 2 is set in the cycle after `linkOnReq` is high. A write of 1 to bit 2 does not clear it while `linkOnReq` is still high.
- R3: Status bit 1 is set in the cycle after `clkPresent` is high. It stays set until the host writes a 1 to bit 1.
- R4: Status bit 0 always equals `clkAbsent`, combinationally and with no latching. A write to bit 0 has no effect.
- R5: A write of 1 to bit 3, 2 or 1 of the status register at address STAT_ADDR clears that bit on the next clock edge, unless its source is high. A read afterwards therefore returns the live state of the source.
- R6: Writing 0 to a status bit leaves that bit unchanged.
- R7: `irq` is a register that holds the OR of (status AND enable) taken at the previous clock edge. It therefore changes one clock after the status or the enable changes.
- R8: During reset, status bits 3 to 1 read 0, status bit 0 follows `clkAbsent`, every enable bit is 0 and `irq` is 0.
- R9: When a source event and a write of 1 to the same status bit fall in the same cycle, the bit ends up set.
- R10: A write to the enable register at address EN_ADDR loads all four enable bits from `wrData`, with bit n enabling status bit n. The enable register reads back the value loaded into it. It does not change when no such write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address (STAT_ADDR or EN_ADDR) |
| wrData | input | 4 | Write data, bit n goes to event bit n |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 4 | Combinational read data, 0 for unmapped addresses |
| initDone | input | 1 | Interface initialization finished |
| linkOnReq | input | 1 | Wake request from the PHY (level) |
| clkPresent | input | 1 | PHY clock detected running |
| clkAbsent | input | 1 | PHY clock detected stopped |
| irq | output | 1 | Host interrupt, active high |

## Verification
The assertions check on every cycle that a source event forces its bit set on the next edge, even when a clear arrives in the same cycle. They also check that a sticky bit survives any cycle without a write-1 to it, that the read path shows the live clock-stopped input, that `irq` is the one-cycle-late OR of the enabled bits, and that the enable register changes only on a write to it. Only the bench scenarios can show the complete sequences. These are: a clear that acts as a live sample, both while the source is still high and after it has dropped; the wake request holding through a clear and then giving way; reset values with the clock-stopped bit following its input during reset; and the interrupt rising and falling at the exact cycles that follow an event and a clear.

// File: rtl/pwr_event_irq_pkg.sv
package pwr_event_irq_pkg;
  localparam int NUM_EVT  = 4;
  localparam int LIVE_BIT = 0;

  // strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic [NUM_EVT-1:1] clr;    // write-1-to-clear per sticky bit
    logic               enLoad; // load enable register
    logic [NUM_EVT-1:0] enVal;  // value for enable register
  } regStrobe_t;
endpackage

// File: rtl/pwr_event_irq_ctrl.sv
module pwr_event_irq_ctrl
  import pwr_event_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int EN_ADDR   = 1
) (
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_EVT-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [NUM_EVT-1:0] statusVec,
  input  logic [NUM_EVT-1:0] enVec,
  output regStrobe_t         strobe,
  output logic [NUM_EVT-1:0] rdData
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);

  logic statHit;
  logic enHit;

  always_comb begin
    statHit       = wrEn && (wrAddr == STAT_A);
    enHit         = wrEn && (wrAddr == EN_A);
    // bit 0 is live status: its write data is dropped here
    strobe.clr    = statHit ? wrData[NUM_EVT-1:1] : '0;
    strobe.enLoad = enHit;
    strobe.enVal  = wrData;
  end

  always_comb begin
    if (rdAddr == STAT_A)    rdData = statusVec;
    else if (rdAddr == EN_A) rdData = enVec;
    else                     rdData = '0;
  end
endmodule

// File: rtl/pwr_event_irq_dp.sv
module pwr_event_irq_dp
  import pwr_event_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evtSrc,
  input  regStrobe_t         strobe,
  output logic [NUM_EVT-1:0] statusVec,
  output logic [NUM_EVT-1:0] enVec,
  output logic               irq
);
  logic [NUM_EVT-1:0] enQ;
  logic               irqQ;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    if (i == LIVE_BIT) begin : g_live
      assign statusVec[i] = evtSrc[i];
    end else begin : g_sticky
      logic stickyQ;
      always_ff @(posedge clk) begin
        if (rst) stickyQ <= 1'b0;
        else     stickyQ <= evtSrc[i] | (stickyQ & ~strobe.clr[i]);
      end
      assign statusVec[i] = stickyQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ  <= '0;
      irqQ <= 1'b0;
    end else begin
      if (strobe.enLoad) enQ <= strobe.enVal;
      irqQ <= |(statusVec & enQ);
    end
  end

  assign enVec = enQ;
  assign irq   = irqQ;
endmodule

// File: rtl/pwr_event_irq.sv
module pwr_event_irq
  import pwr_event_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int EN_ADDR   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_EVT-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_EVT-1:0] rdData,
  input  logic               initDone,
  input  logic               linkOnReq,
  input  logic               clkPresent,
  input  logic               clkAbsent,
  output logic               irq
);
  regStrobe_t         strobe;
  logic [NUM_EVT-1:0] statusVec;
  logic [NUM_EVT-1:0] enVec;
  logic [NUM_EVT-1:0] evtSrc;

  assign evtSrc = {initDone, linkOnReq, clkPresent, clkAbsent};

  pwr_event_irq_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .statusVec(statusVec), .enVec(enVec), .strobe(strobe), .rdData(rdData)
  );

  pwr_event_irq_dp u_dp (
    .clk(clk), .rst(rst), .evtSrc(evtSrc), .strobe(strobe),
    .statusVec(statusVec), .enVec(enVec), .irq(irq)
  );
endmodule

// File: rtl/pwr_event_irq_chk.sv
module pwr_event_irq_chk #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int EN_ADDR   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [3:0]        wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [3:0]        rdData,
  input logic              initDone,
  input logic              linkOnReq,
  input logic              clkPresent,
  input logic              clkAbsent,
  input logic              irq,
  input logic [3:0]        statusVec,
  input logic [3:0]        enVec
);
  logic statWr;
  logic enWr;
  assign statWr = wrEn && (wrAddr == ADDR_W'(STAT_ADDR));
  assign enWr   = wrEn && (wrAddr == ADDR_W'(EN_ADDR));

  // R1, R9: init event wins over a same-cycle clear
  a_r9_init_event_wins: assert property (@(posedge clk) disable iff (rst)
    initDone |=> statusVec[3]);

  // R1: sticky without a write-1
  a_r1_init_sticky: assert property (@(posedge clk) disable iff (rst)
    (statusVec[3] && !(statWr && wrData[3])) |=> statusVec[3]);

  // R2: wake request holds the bit
  a_r2_linkon_held: assert property (@(posedge clk) disable iff (rst)
    linkOnReq |=> statusVec[2]);

  // R3: clock-present sets its bit
  a_r3_clk_present_set: assert property (@(posedge clk) disable iff (rst)
    clkPresent |=> statusVec[1]);

  // R6: writing 0 keeps bit 1
  a_r6_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (statWr && !wrData[1] && statusVec[1]) |=> statusVec[1]);

  // R4: read path shows live clock-absent input
  a_r4_live_readback: assert property (@(posedge clk) disable iff (rst)
    (rdAddr == ADDR_W'(STAT_ADDR)) |-> (rdData[0] == clkAbsent));

  // R7: interrupt is the registered OR of enabled bits
  a_r7_irq_late_or: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(statusVec & enVec))));

  // R10: enables only move on an enable write
  a_r10_enable_stable: assert property (@(posedge clk) disable iff (rst)
    !enWr |=> $stable(enVec));
endmodule

bind pwr_event_irq pwr_event_irq_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .initDone(initDone),
  .linkOnReq(linkOnReq), .clkPresent(clkPresent), .clkAbsent(clkAbsent),
  .irq(irq), .statusVec(statusVec), .enVec(enVec)
);

// File: tb/pwr_event_irq_test.sv
`timescale 1ns/100ps
module pwr_event_irq_test;
  localparam int AW = 4;
  localparam logic [AW-1:0] STAT = 4'd0;
  localparam logic [AW-1:0] EN   = 4'd1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [3:0]    wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [3:0]    rdData;
  logic          initDone = 1'b0;
  logic          linkOnReq = 1'b0;
  logic          clkPresent = 1'b0;
  logic          clkAbsent = 1'b1;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_event_irq uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .initDone(initDone),
    .linkOnReq(linkOnReq), .clkPresent(clkPresent), .clkAbsent(clkAbsent),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [AW-1:0] a, output logic [3:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic tReset();
    logic [3:0] v;
    repeat (2) @(negedge clk);
    readReg(STAT, v); chk("R8 status in reset", v, 4'h1);
    clkAbsent = 1'b0;
    readReg(STAT, v); chk("R8 bit0 follows in reset", v, 4'h0);
    readReg(EN, v);   chk("R8 enable in reset", v, 4'h0);
    chk("R8 irq in reset", {3'b0, irq}, 4'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic tInitSticky();
    logic [3:0] v;
    @(negedge clk); initDone = 1'b1;
    @(negedge clk); initDone = 1'b0;
    readReg(STAT, v); chk("R1 set", v, 4'h8);
    repeat (3) @(negedge clk);
    readReg(STAT, v); chk("R1 sticky", v, 4'h8);
    busWrite(STAT, 4'h0);
    readReg(STAT, v); chk("R6 zero write", v, 4'h8);
    busWrite(STAT, 4'h8);
    readReg(STAT, v); chk("R5 clear bit3", v, 4'h0);
    chk("R7 disabled no irq", {3'b0, irq}, 4'h0);
  endtask

  task automatic tEnable();
    logic [3:0] v;
    busWrite(EN, 4'hA);
    readReg(EN, v); chk("R10 load A", v, 4'hA);
    repeat (2) @(negedge clk);
    busWrite(STAT, 4'hF);
    readReg(EN, v); chk("R10 stable on status write", v, 4'hA);
    busWrite(EN, 4'h0);
    readReg(EN, v); chk("R10 load 0", v, 4'h0);
  endtask

  task automatic tLinkOn();
    logic [3:0] v;
    @(negedge clk); linkOnReq = 1'b1;
    @(negedge clk);
    readReg(STAT, v); chk("R2 set", v, 4'h4);
    busWrite(STAT, 4'h4);
    readReg(STAT, v); chk("R2 held through clear", v, 4'h4);
    linkOnReq = 1'b0;
    @(negedge clk);
    readReg(STAT, v); chk("R2 sticky after drop", v, 4'h4);
    busWrite(STAT, 4'h4);
    readReg(STAT, v); chk("R5 clear bit2 after drop", v, 4'h0);
  endtask

  task automatic tClkPresent();
    logic [3:0] v;
    @(negedge clk); clkPresent = 1'b1;
    @(negedge clk);
    readReg(STAT, v); chk("R3 set", v, 4'h2);
    busWrite(STAT, 4'h2);
    readReg(STAT, v); chk("R5 sample live high", v, 4'h2);
    clkPresent = 1'b0;
    busWrite(STAT, 4'h2);
    readReg(STAT, v); chk("R5 sample live low", v, 4'h0);
  endtask

  task automatic tLiveBit();
    logic [3:0] v;
    @(negedge clk); clkAbsent = 1'b1;
    readReg(STAT, v); chk("R4 live high", v, 4'h1);
    busWrite(STAT, 4'h1);
    readReg(STAT, v); chk("R4 write ignored", v, 4'h1);
    clkAbsent = 1'b0;
    readReg(STAT, v); chk("R4 live low", v, 4'h0);
  endtask

  task automatic tIrq();
    busWrite(EN, 4'h8);
    @(negedge clk); initDone = 1'b1;
    @(negedge clk); initDone = 1'b0;
    chk("R7 irq not yet", {3'b0, irq}, 4'h0);
    @(negedge clk);
    chk("R7 irq rises", {3'b0, irq}, 4'h1);
    busWrite(STAT, 4'h8);
    chk("R7 irq lags clear", {3'b0, irq}, 4'h1);
    @(negedge clk);
    chk("R7 irq falls", {3'b0, irq}, 4'h0);
    busWrite(EN, 4'h1);
    clkAbsent = 1'b1;
    #0.5;
    chk("R7 live bit irq not yet", {3'b0, irq}, 4'h0);
    @(negedge clk);
    chk("R7 live bit irq", {3'b0, irq}, 4'h1);
    clkAbsent = 1'b0;
    busWrite(EN, 4'h0);
    @(negedge clk);
    chk("R7 irq off", {3'b0, irq}, 4'h0);
  endtask

  task automatic tRace();
    logic [3:0] v;
    @(negedge clk);
    initDone = 1'b1; wrEn = 1'b1; wrAddr = STAT; wrData = 4'h8;
    @(negedge clk);
    initDone = 1'b0; wrEn = 1'b0;
    readReg(STAT, v); chk("R9 event beats clear", v, 4'h8);
    busWrite(STAT, 4'h8);
    readReg(STAT, v); chk("R9 later clear works", v, 4'h0);
  endtask

  initial begin
    tReset();
    tInitSticky();
    tEnable();
    tLinkOn();
    tClkPresent();
    tLiveBit();
    tIrq();
    tRace();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule